// File: doc/BRIEF.md
# Half-Word Instruction Fetch Aligner

This block sits between a memory port that only returns whole 32-bit words and a decode stage that expects whole instructions at half-word-aligned program counters. It prefetches words over a read-only request/grant/rvalid interface and keeps a small word queue. It also keeps one spare half-word register. From these it presents either a 16-bit compressed instruction (zero-extended) or a full 32-bit instruction to decode, together with that instruction's own PC, through a valid/ready handshake.

A 32-bit instruction that starts in the upper half of a word is stitched together from that half and the lower half of the next word. A redirect, such as a taken branch, loads a new PC and clears the spare half-word and the word queue. Responses that are still in flight for the old path are counted and discarded as they arrive. The fetch of the new word is offered in the same cycle as the redirect.

Top module: `fa_fetch_align`

## Requirements
- R1: Whenever `mem_req_o` is high, bits [1:0] of `mem_addr_o` are zero.
- R2: Once `mem_req_o` is high in a cycle without `mem_gnt_i`, it is still high in the next cycle.
- R3: No more than NOUT requests are granted and still awaiting their `mem_rvalid_i` at any time.
- R4: A half-word whose bits [1:0] are not 2'b11 is issued as a compressed instruction: `ins_compressed_o` is 1 and `ins_data_o` is the half-word in bits [15:0] with bits [31:16] zero.
- R5: A half-word whose bits [1:0] are 2'b11 starts a 32-bit instruction: `ins_data_o` holds it in bits [15:0] and the next half-word in bits [31:16], including when the two halves come from two different words.
- R6: Every issued instruction carries its own PC. The PC of the next instruction is the previous one plus 2 after a compressed instruction and plus 4 after a 32-bit one.
- R7: In a cycle with `redir_i` high, `ins_valid_o` is low. Any request in that cycle addresses the redirect PC with bits [1:0] cleared. The next issued instruction has the redirect PC with bit 0 cleared, so bit 0 of the redirect PC is ignored.
- R8: Responses to requests that were granted before a redirect are discarded and never reach decode.
- R9: While `ins_valid_o` is high and `ins_ready_i` is low, the offered instruction and PC hold unchanged until it is taken or a redirect arrives.
- R10: With grant always high, every rvalid one cycle after its grant, and decode always ready, one instruction issues in every cycle in steady state.
- R11: While reset is asserted no instruction is offered. The first request after reset addresses RESET_PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| redir_i | input | 1 | Load a new fetch PC this cycle |
| redir_pc_i | input | AW | New PC; bit 0 is ignored |
| mem_req_o | output | 1 | Read request to instruction memory |
| mem_addr_o | output | AW | Word-aligned read address |
| mem_gnt_i | input | 1 | Memory accepted the request |
| mem_rvalid_i | input | 1 | Read data valid, in request order |
| mem_rdata_i | input | 32 | Read data word |
| ins_valid_o | output | 1 | Instruction offered to decode |
| ins_ready_i | input | 1 | Decode takes the instruction |
| ins_data_o | output | 32 | Instruction, compressed ones zero-extended |
| ins_compressed_o | output | 1 | Instruction is 16 bits long |
| ins_pc_o | output | AW | PC of the offered instruction |

## Verification
The bench builds the block with AW=32 and NOUT=2. With two slots, the queue and the outstanding window fill after only a few random grant and rvalid gaps. Redirects therefore often land with one or two stale responses in flight, and the drop counter is exercised at both of its values. Memory contents are a hash of the address, so both instruction lengths, word-crossing instructions and odd-half redirect targets occur often within a few thousand cycles.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef logic [15:0] half_t;

  // a half-word opens a 16-bit instruction unless its two low bits are both set
  function automatic logic is_comp(half_t h);
    return h[1:0] != 2'b11;
  endfunction

  // PC increment for an instruction of the given length
  function automatic logic [2:0] pc_step(logic comp);
    return comp ? 3'd2 : 3'd4;
  endfunction

  // zero-extend a compressed instruction to the output width
  function automatic logic [31:0] widen(half_t h);
    return {16'h0000, h};
  endfunction
endpackage

// File: rtl/fa_word_q.sv
module fa_word_q #(
  parameter int DEPTH = 2,
  parameter int W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic [W-1:0]                 wdata_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 rdata_o,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
  output logic                         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  slot_q [DEPTH];

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_i && !flush_i && wr_q == PW'(i)) slot_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign rdata_o = slot_q[rd_q];
  assign cnt_o   = cnt_q;
  assign empty_o = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !flush_i) |-> (cnt_q < CW'(DEPTH))) else $error("queue overflow"); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o) else $error("queue underflow"); // R8
endmodule

// File: rtl/fa_req_ctrl.sv
module fa_req_ctrl #(
  parameter int AW   = 32,
  parameter int NOUT = 2,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        redir_i,
  input  logic [AW-1:0]               redir_word_i,
  input  logic                        pop_i,
  input  logic [$clog2(NOUT+1)-1:0]   qcnt_i,
  output logic                        mem_req_o,
  output logic [AW-1:0]               mem_addr_o,
  input  logic                        mem_gnt_i,
  input  logic                        mem_rvalid_i,
  output logic                        accept_o
);
  localparam int CW = $clog2(NOUT + 1);

  logic [AW-1:0] fa_q;
  logic          pend_q;
  logic [CW-1:0] out_q, drop_q;
  logic [CW:0]   busy;
  logic          can_req, grant, rv_live;

  always_comb begin
    busy = {1'b0, out_q};
    if (!redir_i) busy = busy + {1'b0, qcnt_i} - (CW+1)'(pop_i);
  end

  assign can_req    = busy < (CW+1)'(NOUT);
  assign mem_req_o  = pend_q | can_req;
  assign mem_addr_o = redir_i ? redir_word_i : fa_q;
  assign grant      = mem_req_o & mem_gnt_i;
  assign rv_live    = mem_rvalid_i & (out_q != '0);
  assign accept_o   = rv_live & (drop_q == '0) & !redir_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_q   <= {RESET_PC[AW-1:2], 2'b00};
      pend_q <= 1'b0;
      out_q  <= '0;
      drop_q <= '0;
    end else begin
      pend_q <= mem_req_o & !mem_gnt_i;
      out_q  <= out_q + CW'(grant) - CW'(rv_live);
      if (redir_i) begin
        fa_q   <= grant ? redir_word_i + AW'(4) : redir_word_i;
        drop_q <= out_q - CW'(rv_live);
      end else begin
        if (grant) fa_q <= fa_q + AW'(4);
        if (rv_live && drop_q != '0) drop_q <= drop_q - CW'(1);
      end
    end
  end

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00)) else $error("unaligned fetch"); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_gnt_i) |=> mem_req_o) else $error("request dropped"); // R2
  AST_OUT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_q <= CW'(NOUT)) else $error("too many outstanding"); // R3
  AST_DROP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q <= out_q) else $error("drop count exceeds outstanding"); // R8
endmodule

// File: rtl/fa_align.sv
module fa_align
  import fa_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redir_i,
  input  logic [AW-1:0] redir_pc_i,
  input  logic [31:0]   head_i,
  input  logic          empty_i,
  input  logic          ins_ready_i,
  output logic          pop_o,
  output logic          ins_valid_o,
  output logic [31:0]   ins_data_o,
  output logic          ins_compressed_o,
  output logic [AW-1:0] ins_pc_o
);
  half_t         hold_q;
  logic          hold_v_q;
  logic [AW-1:0] pc_q;
  half_t         lo;
  logic          comp, avail, fire, load, use_word;

  always_comb begin
    lo       = hold_v_q ? hold_q : (pc_q[1] ? head_i[31:16] : head_i[15:0]);
    comp     = is_comp(lo);
    avail    = 1'b0;
    load     = 1'b0;
    use_word = 1'b0;
    ins_data_o = widen(lo);
    if (hold_v_q) begin
      avail    = comp | !empty_i;
      use_word = !comp;
      if (!comp) ins_data_o = {head_i[15:0], hold_q};
    end else if (pc_q[1]) begin
      load = !empty_i;
    end else begin
      avail    = !empty_i;
      use_word = 1'b1;
      if (!comp) ins_data_o = head_i;
    end
  end

  assign ins_valid_o      = avail & !redir_i;
  assign ins_compressed_o = comp;
  assign ins_pc_o         = pc_q;
  assign fire             = ins_valid_o & ins_ready_i;
  assign pop_o            = !redir_i & ((fire & use_word) | load);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= {RESET_PC[AW-1:1], 1'b0};
      hold_q   <= '0;
      hold_v_q <= 1'b0;
    end else if (redir_i) begin
      pc_q     <= {redir_pc_i[AW-1:1], 1'b0};
      hold_v_q <= 1'b0;
    end else begin
      if (fire) pc_q <= pc_q + AW'(pc_step(comp));
      if (load || (fire && use_word && (!hold_v_q || !comp))) begin
        hold_q <= head_i[31:16];
      end
      if (load) hold_v_q <= 1'b1;
      else if (fire) hold_v_q <= (hold_v_q && !comp) || (!hold_v_q && comp);
    end
  end

  AST_HOLD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v_q |-> pc_q[1]) else $error("spare half without odd pc"); // R5
  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ins_pc_o[0] == 1'b0) else $error("odd byte pc"); // R7
  AST_REDIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    redir_i |-> !ins_valid_o) else $error("valid during redirect"); // R7
  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_o && !ins_ready_i && !redir_i) |=>
      (redir_i || (ins_valid_o && $stable(ins_data_o) && $stable(ins_pc_o))))
    else $error("stalled instruction changed"); // R9
endmodule

// File: rtl/fa_fetch_align.sv
module fa_fetch_align #(
  parameter int AW   = 32,
  parameter int NOUT = 2,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redir_i,
  input  logic [AW-1:0] redir_pc_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          ins_valid_o,
  input  logic          ins_ready_i,
  output logic [31:0]   ins_data_o,
  output logic          ins_compressed_o,
  output logic [AW-1:0] ins_pc_o
);
  localparam int CW = $clog2(NOUT + 1);

  logic [AW-1:0] redir_word;
  logic          pop, accept, q_empty;
  logic [CW-1:0] qcnt;
  logic [31:0]   head;

  assign redir_word = {redir_pc_i[AW-1:2], 2'b00};

  fa_req_ctrl #(.AW(AW), .NOUT(NOUT), .RESET_PC(RESET_PC)) u_req (
    .clk          (clk),
    .rst_n        (rst_n),
    .redir_i      (redir_i),
    .redir_word_i (redir_word),
    .pop_i        (pop),
    .qcnt_i       (qcnt),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .accept_o     (accept)
  );

  fa_word_q #(.DEPTH(NOUT), .W(32)) u_q (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (redir_i),
    .push_i  (accept),
    .wdata_i (mem_rdata_i),
    .pop_i   (pop),
    .rdata_o (head),
    .cnt_o   (qcnt),
    .empty_o (q_empty)
  );

  fa_align #(.AW(AW), .RESET_PC(RESET_PC)) u_al (
    .clk              (clk),
    .rst_n            (rst_n),
    .redir_i          (redir_i),
    .redir_pc_i       (redir_pc_i),
    .head_i           (head),
    .empty_i          (q_empty),
    .ins_ready_i      (ins_ready_i),
    .pop_o            (pop),
    .ins_valid_o      (ins_valid_o),
    .ins_data_o       (ins_data_o),
    .ins_compressed_o (ins_compressed_o),
    .ins_pc_o         (ins_pc_o)
  );
endmodule

// File: tb/sim_fa_fetch_align.sv
module sim_fa_fetch_align;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NOUT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          redir_i = 1'b0;
  logic [AW-1:0] redir_pc_i = '0;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_gnt_i = 1'b0;
  logic          mem_rvalid_i = 1'b0;
  logic [31:0]   mem_rdata_i = '0;
  logic          ins_valid_o;
  logic          ins_ready_i = 1'b0;
  logic [31:0]   ins_data_o;
  logic          ins_compressed_o;
  logic [AW-1:0] ins_pc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fa_fetch_align #(.AW(AW), .NOUT(NOUT)) u0 (.*);

  // bench memory: contents are a hash of the word address
  function automatic logic [31:0] mem_word(logic [31:0] a);
    logic [31:0] x;
    x = (a >> 2) * 32'h9E3779B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EBCA77;
    x = x ^ (x >> 13);
    return x;
  endfunction
  function automatic logic [15:0] half_at(logic [31:0] pc);
    logic [31:0] w;
    w = mem_word(pc & ~32'd3);
    return (pc & 32'd2) != 0 ? w[31:16] : w[15:0];
  endfunction
  function automatic bit short_ins(logic [15:0] h);
    return (h & 16'd3) != 16'd3;
  endfunction
  function automatic logic [31:0] exp_data(logic [31:0] pc);
    logic [15:0] h;
    h = half_at(pc);
    if (short_ins(h)) return {16'd0, h};
    return {half_at(pc + 32'd2), h};
  endfunction

  logic [31:0] mq [8];
  int mh = 0, mt = 0, mcnt = 0;
  int gnt_pct = 100, rv_pct = 100, rdy_pct = 100, redir_pm = 0;
  bit force_redir = 1'b0;
  logic [31:0] force_pc = '0;
  logic [31:0] ref_pc = '0;
  bit prev_req = 0, prev_gnt = 1, prev_stall = 0;
  logic [31:0] prev_data = '0, prev_pc = '0;
  bit s_valid, s_fire;
  logic [31:0] s_pc, s_data;
  bit s_comp;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    bit rv;
    logic [31:0] rpc;
    @(negedge clk);
    rv = (mcnt > 0) && (($urandom % 100) < rv_pct);
    mem_rvalid_i = rv;
    mem_rdata_i  = rv ? mem_word(mq[mh]) : 32'hDEADBEEF;
    mem_gnt_i    = ($urandom % 100) < gnt_pct;
    ins_ready_i  = ($urandom % 100) < rdy_pct;
    if (force_redir) begin
      redir_i = 1'b1; redir_pc_i = force_pc; force_redir = 1'b0;
    end else if (($urandom % 1000) < redir_pm) begin
      rpc = $urandom % 4096;
      redir_i = 1'b1; redir_pc_i = rpc;
    end else begin
      redir_i = 1'b0;
    end
    #1;
    s_valid = ins_valid_o; s_pc = ins_pc_o; s_data = ins_data_o; s_comp = ins_compressed_o;
    s_fire = ins_valid_o && ins_ready_i;
    if (mem_req_o) check(mem_addr_o[1:0] == 2'b00, "R1 aligned address", mem_addr_o, mem_addr_o & ~32'd3);
    if (prev_req && !prev_gnt) check(mem_req_o, "R2 request held", 32'(mem_req_o), 32'd1);
    if (redir_i) begin
      check(!ins_valid_o, "R7 valid low on redirect", 32'(ins_valid_o), 32'd0);
      if (mem_req_o) check(mem_addr_o == (redir_pc_i & ~32'd3), "R7 redirect address", mem_addr_o, redir_pc_i & ~32'd3);
    end else begin
      if (prev_stall) begin
        check(ins_valid_o && ins_data_o == prev_data && ins_pc_o == prev_pc, "R9 stall data", ins_data_o, prev_data);
      end
      if (ins_valid_o) begin
        check(ins_pc_o == ref_pc, "R6 pc", ins_pc_o, ref_pc);
        if (short_ins(half_at(ref_pc))) begin
          check(ins_data_o == exp_data(ref_pc) && ins_compressed_o, "R4 compressed", ins_data_o, exp_data(ref_pc));
        end else begin
          check(ins_data_o == exp_data(ref_pc) && !ins_compressed_o,
                (ref_pc & 32'd2) != 0 ? "R5 spanning" : "R5 full word", ins_data_o, exp_data(ref_pc));
        end
      end
    end
    prev_stall = ins_valid_o && !ins_ready_i && !redir_i;
    prev_data = ins_data_o; prev_pc = ins_pc_o;
    prev_req = mem_req_o; prev_gnt = mem_gnt_i;
    if (redir_i) ref_pc = redir_pc_i & ~32'd1;
    else if (s_fire) ref_pc = ref_pc + (short_ins(half_at(ref_pc)) ? 32'd2 : 32'd4);
    if (rv) begin mh = (mh + 1) % 8; mcnt--; end
    if (mem_req_o && mem_gnt_i) begin
      mq[mt] = mem_addr_o; mt = (mt + 1) % 8; mcnt++;
      if (mcnt > NOUT) check(1'b0, "R3 outstanding", 32'(mcnt), 32'(NOUT));
    end
  endtask

  task automatic wait_valid(int lim);
    for (int i = 0; i < lim; i++) begin
      step();
      if (s_valid && !redir_i) break;
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    int fires;
    void'($urandom(32'd20240611));
    repeat (3) begin
      @(negedge clk);
      check(!ins_valid_o, "R11 no valid in reset", 32'(ins_valid_o), 32'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // first cycle after reset: request at RESET_PC (0)
    #1;
    check(mem_req_o && mem_addr_o == 32'd0, "R11 first address", mem_addr_o, 32'd0);
    ref_pc = 32'd0;
    gnt_pct = 100; rv_pct = 100; rdy_pct = 0;
    step(); step();

    // R9: hold stalled, then release
    repeat (6) step();
    rdy_pct = 100;
    repeat (20) step();

    // R10: throughput with single-cycle memory
    force_redir = 1'b1; force_pc = 32'h100;
    repeat (10) step();
    fires = 0;
    for (int i = 0; i < 100; i++) begin step(); if (s_fire) fires++; end
    check(fires == 100, "R10 throughput", 32'(fires), 32'd100);

    // R5/R7: redirect to odd half with a spanning instruction, bit 0 set
    a = 32'h200;
    for (int i = 0; i < 400; i++) begin
      if (!short_ins(mem_word(a)[31:16])) break;
      a = a + 32'd4;
    end
    force_redir = 1'b1; force_pc = a + 32'd3;
    step();
    wait_valid(20);
    check(s_valid && s_pc == a + 32'd2, "R7 redirect pc bit0 ignored", s_pc, a + 32'd2);
    check(s_data == {mem_word(a + 32'd4)[15:0], mem_word(a)[31:16]} && !s_comp,
          "R5 directed spanning", s_data, {mem_word(a + 32'd4)[15:0], mem_word(a)[31:16]});

    // R8: two responses outstanding, then redirect
    rv_pct = 0; rdy_pct = 0;
    repeat (4) step();
    rv_pct = 100; rdy_pct = 100;
    force_redir = 1'b1; force_pc = 32'h800;
    step();
    wait_valid(20);
    check(s_valid && s_pc == 32'h800 && s_data == exp_data(32'h800), "R8 stale dropped", s_data, exp_data(32'h800));

    // random phase
    gnt_pct = 70; rv_pct = 60; rdy_pct = 75; redir_pm = 40;
    repeat (4000) step();
    gnt_pct = 100; rv_pct = 100; rdy_pct = 100; redir_pm = 10;
    repeat (1000) step();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule